// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Unit

This unit is the on-chip data store of an 8-bit microcontroller core. It accepts one request at a time: a request kind, an 8-bit address, the two register-bank select bits, write data and a single bit value. It turns that request into an access to one of two separate 256-byte RAMs. The core RAM holds the working registers, the bit-addressable bytes and general scratch space. The expanded RAM is used only by external-space moves.

Before it touches storage, the unit rewrites the address. Register accesses are placed in the selected bank. Bit addresses are split into a byte address and a bit position. Direct accesses in the top half of the address map are sent away from RAM and reported as special-function-register accesses, which another block serves. Bit writes are carried out as a read of the containing byte followed by a write-back. During that sequence the unit shows busy for one cycle.

Storage is never cleared by reset, so every location must be written before it is read.

Top module: `dmem_unit`

## Requirements
- R1: Request kind codes on `req_kind` are 0 register, 1 direct, 2 indirect, 3 bit and 4 external; `wr_en`=1 makes the request a write. For addresses 00h to 7Fh, direct and indirect requests reach the same core RAM byte.
- R2: A register request with `req_addr[2:0]`=n and `bank_sel`=b reaches core byte 8*b+n. Banks 0..3 therefore cover 00h-07h, 08h-0Fh, 10h-17h and 18h-1Fh.
- R3: A bit address below 80h selects core byte 20h + (bitaddr/8), bit position bitaddr mod 8. A bit read returns that bit on `bit_out`, with `done` high in the cycle after acceptance.
- R4: A bit write to RAM takes two cycles. `busy` is high and `done` is low in the cycle after acceptance, and `done` is high in the cycle after that. Only the selected bit of the containing byte changes; the other seven bits keep their values.
- R5: Indirect requests to 80h-FFh reach the upper 128 bytes of core RAM.
- R6: A direct request to 80h-FFh leaves both RAMs unchanged. It completes with `done` and `sfr_sel` high and `rd_data` equal to 0.
- R7: A bit request with bit address 80h-FFh changes no RAM byte. It completes in one cycle with `sfr_sel` high and `bit_out` low.
- R8: External requests reach a separate 256-byte expanded RAM at 00h-FFh. Writes to it do not change core RAM, and no other request kind writes it.
- R9: Byte reads and writes raise `done` in the cycle after acceptance, with read data valid in that cycle. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state (storage is not reset) |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Request kind: 0 register, 1 direct, 2 indirect, 3 bit, 4 external |
| req_addr | input | 8 | Byte address, register number in [2:0], or bit address |
| bank_sel | input | 2 | Register bank select |
| wr_en | input | 1 | 1 = write, 0 = read |
| wr_data | input | 8 | Byte write data |
| bit_val | input | 1 | Value for bit writes |
| busy | output | 1 | Bit write back in progress; requests are not accepted |
| done | output | 1 | One-cycle completion pulse |
| sfr_sel | output | 1 | Completed access belongs to special-function-register space |
| rd_data | output | 8 | Byte read result, valid with `done` |
| bit_out | output | 1 | Bit read result, valid with `done` |

## Verification
Assertions check the following on every cycle:
- A busy cycle lasts exactly one cycle and ends with `done`.
- A write-back changes no bit other than the selected one.
- Special-function-register hits never enable a RAM write and always complete with zero data.
- Register requests stay inside the selected bank window.
- Only external requests write the expanded RAM.

Other behaviour can only be shown by the bench's scenarios, which write every location and read it back through a different path:
- Direct and indirect requests alias in the lower half.
- The upper half is separate from direct space.
- Bit addresses map to the correct bytes and bit positions.
- The two RAMs are independent.
- A request presented during the busy cycle has no effect.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int POS_W  = 3;
  localparam int BANK_W = 2;
  localparam logic [ADDR_W-1:0] BIT_AREA_BASE = 8'h20;

  typedef enum logic [2:0] {
    K_REG = 3'd0,
    K_DIR = 3'd1,
    K_IND = 3'd2,
    K_BIT = 3'd3,
    K_EXT = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_CORE = 2'd1,
    SRC_EXT  = 2'd2
  } src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RMW  = 1'b1
  } st_e;

  // Register number n in bank b sits at byte b*8+n.
  function automatic logic [ADDR_W-1:0] bank_reg_addr(input logic [BANK_W-1:0] bank,
                                                      input logic [POS_W-1:0] n);
    return {3'b000, bank, n};
  endfunction

  // Bit address (below 80h) to the byte that contains it.
  function automatic logic [ADDR_W-1:0] bit_byte_addr(input logic [6:0] ba);
    return BIT_AREA_BASE + {4'b0000, ba[6:3]};
  endfunction

  // Replace one bit of a byte.
  function automatic logic [BYTE_W-1:0] put_bit(input logic [BYTE_W-1:0] b,
                                                input logic [POS_W-1:0] pos,
                                                input logic v);
    logic [BYTE_W-1:0] r;
    r = b;
    r[pos] = v;
    return r;
  endfunction
endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-before-write synchronous port; contents have no reset.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/dmem_addr_map.sv
module dmem_addr_map
  import dmem_pkg::*;
(
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] phys,
  output logic [POS_W-1:0]  bitpos,
  output logic              sfr_hit,
  output logic              core_byte,
  output logic              core_bit,
  output logic              ext_hit
);
  always_comb begin
    phys      = addr;
    bitpos    = addr[POS_W-1:0];
    sfr_hit   = 1'b0;
    core_byte = 1'b0;
    core_bit  = 1'b0;
    ext_hit   = 1'b0;
    case (kind)
      K_REG: begin
        phys      = bank_reg_addr(bank, addr[POS_W-1:0]);
        core_byte = 1'b1;
      end
      K_DIR: begin
        if (addr[ADDR_W-1]) sfr_hit = 1'b1;
        else core_byte = 1'b1;
      end
      K_IND: core_byte = 1'b1;
      K_BIT: begin
        if (addr[ADDR_W-1]) sfr_hit = 1'b1;
        else begin
          phys     = bit_byte_addr(addr[6:0]);
          core_bit = 1'b1;
        end
      end
      K_EXT: ext_hit = 1'b1;
      default: ;
    endcase
  end

  // R6 / R7: a special-function-register hit never also targets RAM
  always_comb begin
    assert_sfr_exclusive_R6: assert (!(sfr_hit === 1'b1 && (core_byte || core_bit || ext_hit)));
  end
endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              bit_val,
  input  logic [ADDR_W-1:0] phys,
  input  logic [POS_W-1:0]  bitpos,
  input  logic              sfr_hit,
  input  logic              core_byte,
  input  logic              core_bit,
  input  logic              ext_hit,
  input  logic [BYTE_W-1:0] core_rdata,
  input  logic [BYTE_W-1:0] ext_rdata,
  output logic              core_en,
  output logic              core_we,
  output logic [ADDR_W-1:0] core_addr,
  output logic [BYTE_W-1:0] core_wdata,
  output logic              ext_en,
  output logic              ext_we,
  output logic              busy,
  output logic              done,
  output logic              sfr_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              bit_out
);
  st_e               st;
  logic              accept;
  logic              start_rmw;
  logic [ADDR_W-1:0] addr_q;
  logic [POS_W-1:0]  pos_q;
  logic              val_q;
  logic              done_q;
  logic              sfr_q;
  src_e              src_q;

  assign accept    = req_valid && (st == ST_IDLE);
  assign start_rmw = accept && core_bit && wr_en;
  assign busy      = (st == ST_RMW);

  always_comb begin
    core_en    = 1'b0;
    core_we    = 1'b0;
    core_addr  = phys;
    core_wdata = wr_data;
    if (st == ST_RMW) begin
      core_en    = 1'b1;
      core_we    = 1'b1;
      core_addr  = addr_q;
      core_wdata = put_bit(core_rdata, pos_q, val_q);
    end else if (accept && (core_byte || core_bit)) begin
      core_en = 1'b1;
      core_we = wr_en && core_byte;
    end
  end

  assign ext_en = accept && ext_hit;
  assign ext_we = ext_en && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
      sfr_q  <= 1'b0;
      src_q  <= SRC_ZERO;
      addr_q <= '0;
      pos_q  <= '0;
      val_q  <= 1'b0;
    end else begin
      done_q <= (accept && !start_rmw) || (st == ST_RMW);
      st     <= start_rmw ? ST_RMW : ST_IDLE;
      if (accept) begin
        sfr_q  <= sfr_hit;
        pos_q  <= bitpos;
        val_q  <= bit_val;
        addr_q <= phys;
        if (ext_hit) src_q <= SRC_EXT;
        else if (core_byte || core_bit) src_q <= SRC_CORE;
        else src_q <= SRC_ZERO;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_CORE: rd_data = core_rdata;
      SRC_EXT:  rd_data = ext_rdata;
      default:  rd_data = '0;
    endcase
  end

  assign bit_out = (src_q == SRC_CORE) ? core_rdata[pos_q] : 1'b0;
  assign done    = done_q;
  assign sfr_sel = done_q && sfr_q;

  // R4: the busy phase lasts one cycle and finishes with done
  assert_rmw_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));

  // R4: write-back alters no bit other than the selected one
  assert_rmw_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((core_wdata ^ core_rdata) & ~(8'd1 << pos_q)) == 8'd0));

  // R6 / R7: special-function-register hits never write RAM
  assert_sfr_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sfr_hit) |-> (!core_we && !ext_we));

  // R6: completion in special-function-register space returns zeros
  assert_sfr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> (rd_data == 8'd0 && !bit_out));

  // R9: anything other than a RAM bit write completes next cycle
  assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start_rmw) |=> done);
endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              bit_val,
  output logic              busy,
  output logic              done,
  output logic              sfr_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              bit_out
);
  kind_e             kind;
  logic [ADDR_W-1:0] phys;
  logic [POS_W-1:0]  bitpos;
  logic              sfr_hit, core_byte, core_bit, ext_hit;
  logic              core_en, core_we, ext_en, ext_we;
  logic [ADDR_W-1:0] core_addr;
  logic [BYTE_W-1:0] core_wdata, core_rdata, ext_rdata;

  assign kind = kind_e'(req_kind);

  dmem_addr_map u_map (
    .kind      (kind),
    .addr      (req_addr),
    .bank      (bank_sel),
    .phys      (phys),
    .bitpos    (bitpos),
    .sfr_hit   (sfr_hit),
    .core_byte (core_byte),
    .core_bit  (core_bit),
    .ext_hit   (ext_hit)
  );

  dmem_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .bit_val    (bit_val),
    .phys       (phys),
    .bitpos     (bitpos),
    .sfr_hit    (sfr_hit),
    .core_byte  (core_byte),
    .core_bit   (core_bit),
    .ext_hit    (ext_hit),
    .core_rdata (core_rdata),
    .ext_rdata  (ext_rdata),
    .core_en    (core_en),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .ext_en     (ext_en),
    .ext_we     (ext_we),
    .busy       (busy),
    .done       (done),
    .sfr_sel    (sfr_sel),
    .rd_data    (rd_data),
    .bit_out    (bit_out)
  );

  dmem_ram #(.DATA_W(BYTE_W), .ADDR_W(ADDR_W)) u_core_ram (
    .clk   (clk),
    .en    (core_en),
    .we    (core_we),
    .addr  (core_addr),
    .wdata (core_wdata),
    .rdata (core_rdata)
  );

  dmem_ram #(.DATA_W(BYTE_W), .ADDR_W(ADDR_W)) u_ext_ram (
    .clk   (clk),
    .en    (ext_en),
    .we    (ext_we),
    .addr  (req_addr),
    .wdata (wr_data),
    .rdata (ext_rdata)
  );

  // R2: register requests stay in the selected bank window
  assert_bank_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && kind == K_REG) |->
      (core_addr[7:5] == 3'b000 && core_addr[4:3] == bank_sel));

  // R8: only external requests write the expanded RAM
  assert_ext_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (kind == K_EXT && req_valid));
endmodule

// File: tb/test_dmem_unit.sv
`timescale 1ns/1ps
module test_dmem_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [7:0] req_addr = 8'd0;
  logic [1:0] bank_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       bit_val = 1'b0;
  logic       busy, done, sfr_sel, bit_out;
  logic [7:0] rd_data;

  localparam logic [2:0] KR = 3'd0, KD = 3'd1, KI = 3'd2, KB = 3'd3, KE = 3'd4;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] cm [256];
  logic [7:0] em [256];

  logic       o_done, o_sfr, o_bit, mid_busy, mid_done;
  logic [7:0] o_rd;

  always #2 clk = ~clk;

  dmem_unit i_dmem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .bank_sel(bank_sel), .wr_en(wr_en), .wr_data(wr_data),
    .bit_val(bit_val), .busy(busy), .done(done), .sfr_sel(sfr_sel),
    .rd_data(rd_data), .bit_out(bit_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic issue(input logic [2:0] k, input logic [7:0] a, input logic [1:0] b,
                       input logic w, input logic [7:0] d, input logic v, input bit two);
    req_kind = k; req_addr = a; bank_sel = b; wr_en = w; wr_data = d; bit_val = v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (two) begin
      mid_busy = busy;
      mid_done = done;
      @(negedge clk);
    end
    o_done = done; o_rd = rd_data; o_bit = bit_out; o_sfr = sfr_sel;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset", "done", done, 0);
    chk("reset", "busy", busy, 0);
    chk("reset", "sfr_sel", sfr_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: direct write, indirect read across 00h-7Fh
    for (int a = 0; a < 128; a++) begin
      cm[a] = 8'(a * 13 + 5);
      issue(KD, 8'(a), 2'd0, 1'b1, cm[a], 1'b0, 0);
    end
    for (int a = 0; a < 128; a++) begin
      issue(KI, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R1", "indirect read of direct write", o_rd, cm[a]);
      chk("R9", "byte read done", o_done, 1);
    end
    // R1: indirect write, direct read
    for (int a = 0; a < 128; a += 3) begin
      cm[a] = ~8'(a);
      issue(KI, 8'(a), 2'd0, 1'b1, cm[a], 1'b0, 0);
      chk("R9", "byte write done", o_done, 1);
      issue(KD, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R1", "direct read of indirect write", o_rd, cm[a]);
      chk("R1", "sfr_sel low below 80h", o_sfr, 0);
    end

    // R5: upper half by indirect access
    for (int a = 128; a < 256; a++) begin
      cm[a] = 8'(a * 3 + 1);
      issue(KI, 8'(a), 2'd0, 1'b1, cm[a], 1'b0, 0);
    end
    for (int a = 128; a < 256; a++) begin
      issue(KI, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R5", "upper indirect read", o_rd, cm[a]);
    end

    // R6: direct 80h-FFh goes to special-function space
    for (int a = 128; a < 256; a += 5) begin
      issue(KD, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R6", "direct sfr read done", o_done, 1);
      chk("R6", "direct sfr read flag", o_sfr, 1);
      chk("R6", "direct sfr read data", o_rd, 0);
      issue(KD, 8'(a), 2'd0, 1'b1, 8'hFF ^ cm[a], 1'b0, 0);
      chk("R6", "direct sfr write flag", o_sfr, 1);
      issue(KI, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R6", "upper byte untouched by direct write", o_rd, cm[a]);
      chk("R6", "indirect flag low", o_sfr, 0);
    end

    // R2: register banks
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        cm[8*b+n] = 8'((8*b + n) * 5 + 8'h11);
        issue(KR, 8'(8'hF8 | n), 2'(b), 1'b1, cm[8*b+n], 1'b0, 0);
      end
    end
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        issue(KI, 8'(8*b+n), 2'd0, 1'b0, 8'd0, 1'b0, 0);
        chk("R2", "indirect view of register", o_rd, cm[8*b+n]);
        issue(KR, 8'(n), 2'(b), 1'b0, 8'd0, 1'b0, 0);
        chk("R2", "register read", o_rd, cm[8*b+n]);
      end
    end

    // R3 / R4: every bit address below 80h
    for (int ba = 0; ba < 128; ba++) begin
      logic v;
      int byte_a;
      v = ^8'(ba * 3 + 1);
      byte_a = 32 + ba / 8;
      issue(KB, 8'(ba), 2'd0, 1'b1, 8'd0, v, 1);
      chk("R4", "busy during write back", mid_busy, 1);
      chk("R4", "done low during write back", mid_done, 0);
      chk("R4", "done after write back", o_done, 1);
      cm[byte_a][ba % 8] = v;
      issue(KB, 8'(ba), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R3", "bit read done", o_done, 1);
      chk("R3", "bit read value", o_bit, v);
      issue(KI, 8'(byte_a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R4", "containing byte", o_rd, cm[byte_a]);
    end

    // R7: bit addresses 80h-FFh
    for (int ba = 128; ba < 256; ba += 7) begin
      issue(KB, 8'(ba), 2'd0, 1'b1, 8'd0, ~cm[32 + (ba % 128) / 8][ba % 8], 0);
      chk("R7", "sfr bit write done", o_done, 1);
      chk("R7", "sfr bit write flag", o_sfr, 1);
      issue(KB, 8'(ba), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R7", "sfr bit read flag", o_sfr, 1);
      chk("R7", "sfr bit read value", o_bit, 0);
    end
    for (int a = 32; a < 48; a++) begin
      issue(KI, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R7", "bit area unchanged", o_rd, cm[a]);
    end

    // R8: expanded RAM is separate
    for (int a = 0; a < 256; a++) begin
      em[a] = 8'(a) ^ 8'hC3;
      issue(KE, 8'(a), 2'd0, 1'b1, em[a], 1'b0, 0);
    end
    for (int a = 0; a < 256; a++) begin
      issue(KI, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R8", "core unchanged by external writes", o_rd, cm[a]);
    end
    for (int a = 0; a < 256; a++) begin
      issue(KE, 8'(a), 2'd0, 1'b0, 8'd0, 1'b0, 0);
      chk("R8", "external read", o_rd, em[a]);
      chk("R8", "external flag low", o_sfr, 0);
    end

    // R9: a request during busy is ignored
    req_kind = KB; req_addr = 8'h05; wr_en = 1'b1; bit_val = ~cm[32][5];
    req_valid = 1'b1;
    cm[32][5] = bit_val;
    @(negedge clk);
    chk("R9", "busy while request held", busy, 1);
    req_kind = KD; req_addr = 8'h40; wr_data = ~cm[8'h40];
    @(negedge clk);
    chk("R9", "write back done", done, 1);
    req_valid = 1'b0;
    issue(KD, 8'h40, 2'd0, 1'b0, 8'd0, 1'b0, 0);
    chk("R9", "request during busy had no effect", o_rd, cm[8'h40]);
    issue(KI, 8'h20, 2'd0, 1'b0, 8'd0, 1'b0, 0);
    chk("R4", "bit written before ignored request", o_rd, cm[32]);

    report();
  end
endmodule